// File: doc/BRIEF.md
# Audio Sample Input Formatter

This block sits behind a single shared data port of an audio transmitter. Software or a transfer engine writes 32-bit words into that port. The block cuts a sample out of each word and turns it into a sign-correct 24-bit audio slot. It then places the slot in one of two small per-channel FIFOs, and a downstream serializer takes the slots a frame at a time. A frame is one slot from each channel.

Several mode inputs control how a word becomes a sample:

- the container width, in bytes;
- the number of valid bits;
- the byte order;
- whether the sample sits at the top or the bottom of its container;
- how writes are assigned to channels: indexed, alternating, or packed pairs.

In mono operation every sample is sent to both channels. Five status flags report the fill state of the FIFOs. A clear command and a reset command each empty the FIFOs and return the alternation pointer to channel 1.

Top module: `audio_word_formatter`

## Requirements
- R1: Sample shaping.
  - The container is the low `bytes_m1+1` bytes of the word.
  - With `big_end`=1 the byte order inside the container is reversed.
  - With `msb_just`=0 the sample is the low `vbits` bits of the container. With `msb_just`=1 it is the top `vbits` bits.
  - The sample is left-aligned into a 24-bit slot with zeros below it. Samples wider than 24 bits keep only their top 24 bits.
- R2: A `vbits` of 0, or a `vbits` larger than the container width, is treated as the full container width.
- R3: With `dual_ch`=0, each accepted write pushes the same slot into both channels.
- R4: Alternating mode (`acc_mode`=1, `dual_ch`=1).
  - Accepted writes go to channel 1, then channel 2, and so on, starting with channel 1.
  - A dropped write does not advance the pointer.
- R5: Indexed mode (`acc_mode`=0, `dual_ch`=1): `wr_idx`=0 targets channel 1 and `wr_idx`=1 targets channel 2.
- R6: Paired mode (`acc_mode`=2).
  - Bits 15:0 feed channel 1 and bits 31:16 feed channel 2.
  - Each half is a 2-byte container and `bytes_m1` is ignored.
  - `vbits` above 16 is treated as 16.
- R7: A write with `acc_mode`=3 is ignored.
- R8: The serializer handshake.
  - `frame_valid` is high when both channel FIFOs hold a slot.
  - A cycle with `frame_take` and `frame_valid` both high pops one slot from each channel.
  - Slots leave in write order, shown on `out_ch1` and `out_ch2`.
- R9: The fill flags.
  - `st_empty` is high when both FIFOs are empty.
  - `st_full` is high when either FIFO holds FIFO_DEPTH slots.
  - `st_ready` is high when no FIFO is full.
- R10: `st_chunk` is high when the smaller free-entry count of the two FIFOs is at least `chunk_thr`.
- R11: Overrun.
  - A write that targets a full FIFO is dropped for both channels.
  - The drop sets `st_overrun`, which stays set until a clear or reset command.
- R12: A cycle with `cmd_clear` or `cmd_reset` high does all of the following:
  - empties both FIFOs;
  - clears `st_overrun`;
  - returns the alternation pointer to channel 1;
  - discards any write in the same cycle.
- R13: After `rst`, the FIFOs are empty, `st_ready`=1, `st_full`=0, `st_overrun`=0 and `frame_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the data port |
| wr_idx | input | 1 | Channel select in indexed mode |
| wr_data | input | 32 | Written data word |
| cmd_clear | input | 1 | FIFO clear command |
| cmd_reset | input | 1 | Soft reset command |
| acc_mode | input | 2 | 0 indexed, 1 alternating, 2 paired, 3 reserved |
| big_end | input | 1 | Byte order within container (1 = big-endian) |
| msb_just | input | 1 | Sample at top of container when 1 |
| vbits | input | 6 | Valid bits per sample |
| bytes_m1 | input | 2 | Container bytes minus one |
| chunk_thr | input | 4 | Free-entry threshold for st_chunk |
| dual_ch | input | 1 | 1 = two channels, 0 = mono |
| frame_take | input | 1 | Serializer takes a frame |
| frame_valid | output | 1 | A frame is available |
| out_ch1 | output | 24 | Channel 1 slot at FIFO head |
| out_ch2 | output | 24 | Channel 2 slot at FIFO head |
| st_ready | output | 1 | A write can be accepted |
| st_empty | output | 1 | Both FIFOs empty |
| st_full | output | 1 | A FIFO is full |
| st_chunk | output | 1 | Free space reaches the chunk threshold |
| st_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default FIFO_DEPTH of 4, so a FIFO becomes full after four mono writes or eight alternating writes. That puts the full, chunk and overrun corners within a few dozen cycles. It also makes it possible to show that a dropped write leaves the alternation pointer where it was, by taking one frame from a full pair of FIFOs and refilling it. A table walks the shaping rules across every container width, both byte orders and both justifications. Directed sequences then cover the three access modes, the clamp of the valid-bits field and the clear priority.

// File: rtl/awf_pkg.sv
package awf_pkg;

    localparam int WORD_W = 32;
    localparam int SLOT_W = 24;

    typedef enum logic [1:0] {
        ACC_INDEX  = 2'd0,
        ACC_TOGGLE = 2'd1,
        ACC_PAIR   = 2'd2,
        ACC_RSVD   = 2'd3
    } acc_e;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic       big;
        logic       msb;
        logic [1:0] bytes_m1;
        logic [5:0] vbits;
    } fmt_cfg_t;

    typedef struct packed {
        logic  push1;
        logic  push2;
        slot_t s1;
        slot_t s2;
    } push_t;

    // Cut a sample out of the low nbytes of w and left-align it into a slot.
    function automatic slot_t shape(input logic [WORD_W-1:0] w,
                                    input logic [2:0] nbytes,
                                    input fmt_cfg_t cfg);
        logic [WORD_W-1:0] rev;
        logic [WORD_W-1:0] cont;
        logic [63:0]       msk;
        logic [63:0]       t;
        int                cw;
        int                v;
        cw = 8 * int'(nbytes);
        v  = int'(cfg.vbits);
        if (v == 0 || v > cw) v = cw;
        msk = (64'd1 << cw) - 64'd1;
        rev = {w[7:0], w[15:8], w[23:16], w[31:24]};
        if (cfg.big) cont = rev >> (WORD_W - cw);
        else         cont = w & msk[WORD_W-1:0];
        if (cfg.msb) begin
            t = {32'd0, cont} << (WORD_W - cw);
            t = t & ~((64'd1 << (WORD_W - v)) - 64'd1);
        end else begin
            t = {32'd0, cont} << (WORD_W - v);
        end
        return t[WORD_W-1:WORD_W-SLOT_W];
    endfunction

endpackage

// File: rtl/awf_unpack.sv
module awf_unpack
    import awf_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        acc_mode,
    input  fmt_cfg_t          cfg,
    input  logic              dual_ch,
    input  logic              tgl_ptr,
    output push_t             req
);

    logic [2:0] nb;
    slot_t      whole;
    slot_t      lo;
    slot_t      hi;

    always_comb begin
        nb    = {1'b0, cfg.bytes_m1} + 3'd1;
        whole = shape(wr_data, nb, cfg);
        lo    = shape({16'd0, wr_data[15:0]}, 3'd2, cfg);
        hi    = shape({16'd0, wr_data[31:16]}, 3'd2, cfg);
        req   = '0;
        case (acc_e'(acc_mode))
            ACC_INDEX: begin
                req.s1    = whole;
                req.s2    = whole;
                req.push1 = ~wr_idx;
                req.push2 = wr_idx;
            end
            ACC_TOGGLE: begin
                req.s1    = whole;
                req.s2    = whole;
                req.push1 = ~tgl_ptr;
                req.push2 = tgl_ptr;
            end
            ACC_PAIR: begin
                req.s1    = lo;
                req.s2    = hi;
                req.push1 = 1'b1;
                req.push2 = 1'b1;
            end
            default: ;
        endcase
        if (!dual_ch && acc_e'(acc_mode) != ACC_RSVD) begin
            req.s2    = req.s1;
            req.push1 = 1'b1;
            req.push2 = 1'b1;
        end
        if (!wr_en) begin
            req.push1 = 1'b0;
            req.push2 = 1'b0;
        end
    end

endmodule

// File: rtl/awf_fifo.sv
module awf_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp;
    logic [AW-1:0] wp;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !rst && !clr) mem[wp] <= din;
    end

endmodule

// File: rtl/audio_word_formatter.sv
module audio_word_formatter
    import awf_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cmd_clear,
    input  logic              cmd_reset,
    input  logic [1:0]        acc_mode,
    input  logic              big_end,
    input  logic              msb_just,
    input  logic [5:0]        vbits,
    input  logic [1:0]        bytes_m1,
    input  logic [3:0]        chunk_thr,
    input  logic              dual_ch,
    input  logic              frame_take,
    output logic              frame_valid,
    output logic [SLOT_W-1:0] out_ch1,
    output logic [SLOT_W-1:0] out_ch2,
    output logic              st_ready,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_chunk,
    output logic              st_overrun
);

    localparam int NCH   = 2;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    fmt_cfg_t         cfg;
    push_t            req;
    logic             tgl_ptr;
    logic             flush;
    logic             blocked;
    logic             accept;
    logic             pop;
    logic [NCH-1:0]   want;
    logic [NCH-1:0]   f_push;
    logic [NCH-1:0]   f_full;
    logic [NCH-1:0]   f_empty;
    slot_t            f_din  [NCH];
    slot_t            f_dout [NCH];
    logic [CNT_W-1:0] f_cnt  [NCH];
    logic [CNT_W-1:0] min_free;

    assign cfg   = '{big: big_end, msb: msb_just, bytes_m1: bytes_m1, vbits: vbits};
    assign flush = cmd_clear | cmd_reset;

    awf_unpack u_unpack (
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .acc_mode (acc_mode),
        .cfg      (cfg),
        .dual_ch  (dual_ch),
        .tgl_ptr  (tgl_ptr),
        .req      (req)
    );

    assign want     = {req.push2, req.push1};
    assign f_din[0] = req.s1;
    assign f_din[1] = req.s2;
    assign blocked  = |(want & f_full);
    assign accept   = (|want) & ~blocked & ~flush;
    assign f_push   = accept ? want : '0;

    assign frame_valid = &(~f_empty);
    assign pop         = frame_take & frame_valid;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            awf_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk   (clk),
                .rst   (rst),
                .clr   (flush),
                .push  (f_push[g]),
                .pop   (pop),
                .din   (f_din[g]),
                .dout  (f_dout[g]),
                .count (f_cnt[g]),
                .full  (f_full[g]),
                .empty (f_empty[g])
            );
        end
    endgenerate

    assign out_ch1 = f_dout[0];
    assign out_ch2 = f_dout[1];

    always_comb begin
        min_free = CNT_W'(FIFO_DEPTH);
        for (int i = 0; i < NCH; i++) begin
            if (CNT_W'(FIFO_DEPTH) - f_cnt[i] < min_free)
                min_free = CNT_W'(FIFO_DEPTH) - f_cnt[i];
        end
    end

    assign st_full  = |f_full;
    assign st_ready = ~st_full;
    assign st_empty = &f_empty;
    assign st_chunk = (int'(min_free) >= int'(chunk_thr));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tgl_ptr <= 1'b0;
        end else if (accept && dual_ch && acc_e'(acc_mode) == ACC_TOGGLE) begin
            tgl_ptr <= ~tgl_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_overrun <= 1'b0;
        end else if ((|want) && blocked) begin
            st_overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/awf_checker.sv
module awf_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] acc_mode,
    input logic       cmd_clear,
    input logic       cmd_reset,
    input logic       frame_take,
    input logic       frame_valid,
    input logic       st_empty,
    input logic       st_full,
    input logic       st_overrun
);

    // R9: a FIFO pair cannot be empty and full together
    assert_empty_full_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(st_empty && st_full));

    // R9: a full FIFO stays full while nothing is popped or flushed
    assert_full_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (st_full && !frame_take && !cmd_clear && !cmd_reset) |=> st_full);

    // R8: a frame is offered only when data is held
    assert_frame_has_data_R8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> !st_empty);

    // R12: a flush command leaves the block empty and without overrun
    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_clear || cmd_reset) |=> (st_empty && !st_overrun));

    // R11: overrun is sticky until flushed
    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (st_overrun && !cmd_clear && !cmd_reset) |=> st_overrun);

    // R11: overrun only rises after a write while a FIFO was full
    assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(st_overrun) |-> $past(wr_en && st_full));

    // R7: reserved-mode writes change no fill state
    assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_mode == 2'd3 && !cmd_clear && !cmd_reset && !frame_take)
        |=> ($stable(st_empty) && $stable(st_full)));

endmodule

bind audio_word_formatter awf_checker u_awf_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .acc_mode    (acc_mode),
    .cmd_clear   (cmd_clear),
    .cmd_reset   (cmd_reset),
    .frame_take  (frame_take),
    .frame_valid (frame_valid),
    .st_empty    (st_empty),
    .st_full     (st_full),
    .st_overrun  (st_overrun)
);

// File: tb/sim_audio_word_formatter.sv
module sim_audio_word_formatter;

    localparam int CLK_PERIOD = 10;

    // {big, msb, bytes_m1[1:0], vbits[5:0], data[31:0], expected slot[23:0]}
    localparam logic [65:0] VEC [10] = '{
        {1'b0, 1'b0, 2'd1, 6'd16, 32'h00008123, 24'h812300},
        {1'b1, 1'b0, 2'd1, 6'd16, 32'h00002381, 24'h812300},
        {1'b0, 1'b1, 2'd3, 6'd24, 32'hABCDEF55, 24'hABCDEF},
        {1'b0, 1'b0, 2'd3, 6'd24, 32'h55ABCDEF, 24'hABCDEF},
        {1'b0, 1'b0, 2'd2, 6'd20, 32'hFF0F1234, 24'hF12340},
        {1'b0, 1'b1, 2'd2, 6'd18, 32'h00ABCDEF, 24'hABCDC0},
        {1'b1, 1'b0, 2'd2, 6'd24, 32'h99112233, 24'h332211},
        {1'b0, 1'b0, 2'd0, 6'd8,  32'hFFFFFF80, 24'h800000},
        {1'b0, 1'b0, 2'd3, 6'd32, 32'h12345678, 24'h123456},
        {1'b1, 1'b1, 2'd3, 6'd32, 32'h12345678, 24'h785634}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_idx = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cmd_clear = 1'b0;
    logic        cmd_reset = 1'b0;
    logic [1:0]  acc_mode = 2'd1;
    logic        big_end = 1'b0;
    logic        msb_just = 1'b0;
    logic [5:0]  vbits = 6'd16;
    logic [1:0]  bytes_m1 = 2'd1;
    logic [3:0]  chunk_thr = 4'd1;
    logic        dual_ch = 1'b0;
    logic        frame_take = 1'b0;
    logic        frame_valid;
    logic [23:0] out_ch1;
    logic [23:0] out_ch2;
    logic        st_ready;
    logic        st_empty;
    logic        st_full;
    logic        st_chunk;
    logic        st_overrun;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    audio_word_formatter u0 (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic cfgset(input logic [1:0] m, input logic d, input logic b, input logic ms,
                          input logic [1:0] bm, input logic [5:0] vb, input logic [3:0] ct);
        acc_mode = m; dual_ch = d; big_end = b; msb_just = ms;
        bytes_m1 = bm; vbits = vb; chunk_thr = ct;
    endtask

    task automatic wr(input logic [31:0] d, input logic idx);
        wr_en = 1'b1; wr_data = d; wr_idx = idx;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic flush_cmd(input logic use_reset);
        if (use_reset) cmd_reset = 1'b1; else cmd_clear = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0; cmd_clear = 1'b0;
    endtask

    task automatic take_chk(input string req, input logic [23:0] e1, input logic [23:0] e2);
        chk({req, " frame_valid"}, {31'd0, frame_valid}, 32'd1);
        chk({req, " ch1"}, {8'd0, out_ch1}, {8'd0, e1});
        chk({req, " ch2"}, {8'd0, out_ch2}, {8'd0, e2});
        frame_take = 1'b1;
        @(negedge clk);
        frame_take = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13: reset state
        chk("R13 empty", {31'd0, st_empty}, 32'd1);
        chk("R13 ready", {31'd0, st_ready}, 32'd1);
        chk("R13 full", {31'd0, st_full}, 32'd0);
        chk("R13 overrun", {31'd0, st_overrun}, 32'd0);
        chk("R13 frame_valid", {31'd0, frame_valid}, 32'd0);

        // R1 / R3: shaping table, mono, checks both channels
        for (int i = 0; i < 10; i++) begin
            automatic logic [65:0] v = VEC[i];
            cfgset(2'd1, 1'b0, v[65], v[64], v[63:62], v[61:56], 4'd1);
            wr(v[55:24], 1'b0);
            take_chk("R1 R3 table", v[23:0], v[23:0]);
        end

        // R2: valid-bits clamp
        cfgset(2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 6'd0, 4'd1);
        wr(32'h00001234, 1'b0);
        take_chk("R2 zero vbits", 24'h123400, 24'h123400);
        cfgset(2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd30, 4'd1);
        wr(32'h0000007F, 1'b0);
        take_chk("R2 wide vbits", 24'h7F0000, 24'h7F0000);

        // R6: paired mode
        cfgset(2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 6'd16, 4'd1);
        wr(32'hBEEF1234, 1'b0);
        take_chk("R6 pair le", 24'h123400, 24'hBEEF00);
        cfgset(2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 6'd24, 4'd1);
        wr(32'h3412EFBE, 1'b0);
        take_chk("R6 pair be", 24'hBEEF00, 24'h123400);

        // R4 / R8: alternating mode
        cfgset(2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 6'd16, 4'd2);
        wr(32'h1111, 1'b0);
        chk("R8 half frame", {31'd0, frame_valid}, 32'd0);
        wr(32'h2222, 1'b0);
        wr(32'h3333, 1'b0);
        wr(32'h4444, 1'b0);
        take_chk("R4 frame a", 24'h111100, 24'h222200);
        take_chk("R4 frame b", 24'h333300, 24'h444400);

        // R12: clear returns pointer to channel 1
        wr(32'h5555, 1'b0);
        flush_cmd(1'b0);
        chk("R12 empty after clear", {31'd0, st_empty}, 32'd1);
        wr(32'h6666, 1'b0);
        wr(32'h7777, 1'b0);
        take_chk("R12 pointer", 24'h666600, 24'h777700);

        // R5: indexed mode
        cfgset(2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 6'd16, 4'd1);
        wr(32'hCAFE, 1'b1);
        chk("R5 one side", {31'd0, frame_valid}, 32'd0);
        wr(32'hBEAD, 1'b0);
        take_chk("R5 indexed", 24'hBEAD00, 24'hCAFE00);

        // R7: reserved mode
        cfgset(2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 6'd16, 4'd1);
        wr(32'h9999, 1'b0);
        chk("R7 ignored", {31'd0, st_empty}, 32'd1);

        // R9 / R10 / R11: mono fill
        cfgset(2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 6'd16, 4'd2);
        wr(32'h0A01, 1'b0);
        wr(32'h0A02, 1'b0);
        chk("R10 chunk free2", {31'd0, st_chunk}, 32'd1);
        wr(32'h0A03, 1'b0);
        chk("R10 chunk free1", {31'd0, st_chunk}, 32'd0);
        wr(32'h0A04, 1'b0);
        chk("R9 full", {31'd0, st_full}, 32'd1);
        chk("R9 ready", {31'd0, st_ready}, 32'd0);
        chk("R11 no overrun yet", {31'd0, st_overrun}, 32'd0);
        wr(32'h0A05, 1'b0);
        chk("R11 overrun", {31'd0, st_overrun}, 32'd1);
        take_chk("R11 drain 1", 24'h0A0100, 24'h0A0100);
        take_chk("R11 drain 2", 24'h0A0200, 24'h0A0200);
        take_chk("R11 drain 3", 24'h0A0300, 24'h0A0300);
        take_chk("R11 drain 4", 24'h0A0400, 24'h0A0400);
        chk("R9 empty after drain", {31'd0, st_empty}, 32'd1);
        chk("R11 sticky", {31'd0, st_overrun}, 32'd1);
        flush_cmd(1'b1);
        chk("R12 reset clears overrun", {31'd0, st_overrun}, 32'd0);

        // R4 / R11: dropped write leaves the pointer in place
        cfgset(2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 6'd16, 4'd1);
        for (int k = 1; k <= 8; k++) wr(32'h1000 + k, 1'b0);
        chk("R9 dual full", {31'd0, st_full}, 32'd1);
        wr(32'h2000, 1'b0);
        chk("R11 dual overrun", {31'd0, st_overrun}, 32'd1);
        take_chk("R4 first", 24'h100100, 24'h100200);
        wr(32'hAAAA, 1'b0);
        wr(32'hBBBB, 1'b0);
        take_chk("R4 second", 24'h100300, 24'h100400);
        take_chk("R4 third", 24'h100500, 24'h100600);
        take_chk("R4 fourth", 24'h100700, 24'h100800);
        take_chk("R4 after drop", 24'hAAAA00, 24'hBBBB00);

        // R12: clear wins over a write in the same cycle
        wr_en = 1'b1; wr_data = 32'h4242; cmd_clear = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cmd_clear = 1'b0;
        chk("R12 clear priority", {31'd0, st_empty}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule